// File: doc/BRIEF.md
# Two-Level Adaptive Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps a global shift register with the outcomes of the most recently resolved branches. It also keeps one storage array of two-bit counters that can be viewed as one table or as several. A lookup combines the branch address and the current history into a table index, and it returns the counter's taken bit in the same cycle. The lookup also returns the history value it used, so the pipeline can carry that value forward.

When the branch resolves, the pipeline sends back the branch address, the history value it was given at lookup, and the real outcome. The block uses these to rebuild the same index and train that counter. It also shifts the outcome into the global history.

A run-time input selects one of four ways to form the index. A second input selects one of two counter update rules. Switching either input does not clear the table.

Top module: `twolevel_bpred`

## Requirements
- R1: After reset the history register reads zero and every counter holds weakly taken (10). Every lookup therefore predicts taken.
- R2: Each cycle with `up_valid` high, the history shifts left by one bit and `up_taken` enters at bit 0. The oldest bit falls out at the top.
- R3: Counter codes are 11 strongly taken, 10 weakly taken, 01 weakly not taken and 00 strongly not taken. `lk_taken` is the high bit of the counter that the lookup selects.
- R4: With `hyst_mode` low, an update moves the counter one step toward the outcome. The counter holds at 11 on taken and holds at 00 on not taken.
- R5: With `hyst_mode` high, 10 on not taken goes to 00, and 00 on taken goes to 01.
- R6: With `hyst_mode` high, 01 on taken goes to 11. 11 on not taken goes to 10. 01 on not taken goes to 00. 10 on taken goes to 11.
- R7: With `idx_mode` = 0, the index is the history alone, and the branch address has no effect on the prediction.
- R8: With `idx_mode` = 1, the set field `pc[PC_LSB+SET_W-1:PC_LSB]` picks one of 2^SET_W tables, each indexed by history. The flat index is {set field, history}.
- R9: With `idx_mode` = 2, the flat index is {history, set field}, so the address bits form the low part of the index.
- R10: With `idx_mode` = 3, the flat index is history XOR `pc[PC_LSB+HIST_W-1:PC_LSB]`, with the top SET_W index bits zero.
- R11: An update trains the entry named by `up_pc` and `up_hist`, not by the live history. While `up_valid` is low, neither the history nor any counter changes.
- R12: When two correlated branches repeat an alternating not-taken/taken pattern under per-set indexing, the block makes no mispredictions after a short warm-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| idx_mode | input | 2 | Index scheme: 0 history, 1 per-set, 2 concatenated, 3 XOR |
| hyst_mode | input | 1 | 0 saturating counters, 1 hysteresis counters |
| lk_pc | input | PC_W | Branch address to predict |
| lk_taken | output | 1 | Predicted direction (1 = taken) |
| lk_hist | output | HIST_W | Global history used by this lookup |
| up_valid | input | 1 | Resolved-branch update strobe |
| up_pc | input | PC_W | Address of the resolved branch |
| up_hist | input | HIST_W | History returned by that branch's lookup |
| up_taken | input | 1 | Actual outcome |

## Verification
The checker watches every cycle for four things:
- the history shift and its hold while idle,
- the direction of each saturating counter step,
- the two hysteresis jumps between weak and strong states,
- the rise from 01 straight to 11.

Other behaviour can only be shown by the bench's scenarios. These include:
- the exact index layout of each scheme, including aliasing between the per-set and concatenated layouts and between XOR pairs;
- the holds at both counter limits;
- that the address has no effect under history-only indexing;
- convergence on the correlated two-branch pattern.

// File: rtl/twolevel_bpred.sv
module twolevel_bpred #(
  parameter int PC_W   = 32,
  parameter int HIST_W = 4,
  parameter int SET_W  = 2,
  parameter int PC_LSB = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        idx_mode,
  input  logic              hyst_mode,
  input  logic [PC_W-1:0]   lk_pc,
  output logic              lk_taken,
  output logic [HIST_W-1:0] lk_hist,
  input  logic              up_valid,
  input  logic [PC_W-1:0]   up_pc,
  input  logic [HIST_W-1:0] up_hist,
  input  logic              up_taken
);
  localparam int IDX_W = HIST_W + SET_W;
  localparam int DEPTH = 1 << IDX_W;

  logic [HIST_W-1:0]      hist_q;
  logic [DEPTH-1:0][1:0]  cnt_q;
  logic [IDX_W-1:0]       lk_idx, up_idx;
  logic [1:0]             cnt_old, cnt_new;

  function automatic logic [IDX_W-1:0] make_idx(input logic [1:0] m,
                                                input logic [PC_W-1:0] pc,
                                                input logic [HIST_W-1:0] h);
    logic [SET_W-1:0]  s;
    logic [HIST_W-1:0] a;
    s = pc[PC_LSB +: SET_W];
    a = pc[PC_LSB +: HIST_W];
    case (m)
      2'd0:    return {{SET_W{1'b0}}, h};
      2'd1:    return {s, h};
      2'd2:    return {h, s};
      default: return {{SET_W{1'b0}}, h ^ a};
    endcase
  endfunction

  assign lk_idx   = make_idx(idx_mode, lk_pc, hist_q);
  assign up_idx   = make_idx(idx_mode, up_pc, up_hist);
  assign lk_taken = cnt_q[lk_idx][1];
  assign lk_hist  = hist_q;
  assign cnt_old  = cnt_q[up_idx];

  always_comb begin
    if (!hyst_mode) begin
      if (up_taken) cnt_new = (cnt_old == 2'b11) ? 2'b11 : cnt_old + 2'b01;
      else          cnt_new = (cnt_old == 2'b00) ? 2'b00 : cnt_old - 2'b01;
    end else begin
      case ({up_taken, cnt_old})
        3'b1_00: cnt_new = 2'b01;
        3'b1_01: cnt_new = 2'b11;
        3'b1_10: cnt_new = 2'b11;
        3'b1_11: cnt_new = 2'b11;
        3'b0_11: cnt_new = 2'b10;
        default: cnt_new = 2'b00;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist_q <= '0;
      for (int i = 0; i < DEPTH; i++) cnt_q[i] <= 2'b10;
    end else if (up_valid) begin
      hist_q         <= HIST_W'({hist_q, up_taken});
      cnt_q[up_idx]  <= cnt_new;
    end
  end
endmodule

module twolevel_bpred_chk #(
  parameter int HIST_W = 4,
  parameter int IDX_W  = 6
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          up_valid,
  input logic                          up_taken,
  input logic                          hyst_mode,
  input logic [HIST_W-1:0]             lk_hist,
  input logic [IDX_W-1:0]              up_idx,
  input logic [(1<<IDX_W)-1:0][1:0]    cnt_q
);
  // R2
  hist_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid |=> lk_hist == HIST_W'({$past(lk_hist), $past(up_taken)}));
  // R11
  hist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !up_valid |=> $stable(lk_hist));
  // R4
  sat_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && !hyst_mode && up_taken) |=> cnt_q[$past(up_idx)] >= $past(cnt_q[up_idx]));
  // R4
  sat_dn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && !hyst_mode && !up_taken) |=> cnt_q[$past(up_idx)] <= $past(cnt_q[up_idx]));
  // R5
  hyst_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && hyst_mode && !up_taken && cnt_q[up_idx] == 2'b10) |=> cnt_q[$past(up_idx)] == 2'b00);
  // R6
  hyst_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && hyst_mode && up_taken && cnt_q[up_idx] == 2'b01) |=> cnt_q[$past(up_idx)] == 2'b11);
endmodule

bind twolevel_bpred twolevel_bpred_chk #(.HIST_W(HIST_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .up_valid(up_valid), .up_taken(up_taken),
  .hyst_mode(hyst_mode), .lk_hist(lk_hist), .up_idx(up_idx), .cnt_q(cnt_q));

// File: tb/twolevel_bpred_bench.sv
`timescale 1ns/1ps
module twolevel_bpred_bench;
  localparam int PC_W = 32, HIST_W = 4, SET_W = 2, PC_LSB = 2;

  logic clk = 0, rst_n = 0, hyst_mode = 0, lk_taken, up_valid = 0, up_taken = 0;
  logic [1:0] idx_mode = 0;
  logic [PC_W-1:0] lk_pc = 0, up_pc = 0;
  logic [HIST_W-1:0] lk_hist, up_hist = 0;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  twolevel_bpred #(.PC_W(PC_W), .HIST_W(HIST_W), .SET_W(SET_W), .PC_LSB(PC_LSB)) u_twolevel_bpred (
    .clk(clk), .rst_n(rst_n), .idx_mode(idx_mode), .hyst_mode(hyst_mode),
    .lk_pc(lk_pc), .lk_taken(lk_taken), .lk_hist(lk_hist),
    .up_valid(up_valid), .up_pc(up_pc), .up_hist(up_hist), .up_taken(up_taken));

  function automatic logic [PC_W-1:0] pcf(input int f);
    return PC_W'(f) << PC_LSB;
  endfunction

  task automatic chk(input int act, input int exp, input string req);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic upd(input int f, input int h, input logic t);
    @(negedge clk);
    up_valid = 1; up_pc = pcf(f); up_hist = HIST_W'(h); up_taken = t;
    @(negedge clk);
    up_valid = 0;
  endtask

  task automatic set_hist(input int h);
    for (int i = HIST_W-1; i >= 0; i--) upd(0, 15, h[i]);
  endtask

  task automatic look(input int f, input int exp, input string req);
    lk_pc = pcf(f); #1;
    chk(int'(lk_taken), exp, req);
  endtask

  task automatic t_reset();
    do_reset();
    #1 chk(int'(lk_hist), 0, "R1 history");
    for (int m = 0; m < 4; m++) begin
      idx_mode = 2'(m);
      look(m * 5 + 1, 1, "R1 weakly taken");
    end
    idx_mode = 0;
  endtask

  task automatic t_history();
    upd(0, 15, 1); upd(0, 15, 0); upd(0, 15, 1); upd(0, 15, 1);
    #1 chk(int'(lk_hist), 4'b1011, "R2 shift order");
    upd(0, 15, 0);
    #1 chk(int'(lk_hist), 4'b0110, "R2 oldest drops");
    @(negedge clk); up_pc = pcf(0); up_hist = 0; up_taken = 1;
    @(negedge clk); @(negedge clk);
    #1 chk(int'(lk_hist), 4'b0110, "R11 idle history");
  endtask

  task automatic t_saturate();
    idx_mode = 0; hyst_mode = 0;
    upd(0, 0, 1); set_hist(0); look(0, 1, "R4 10->11");
    upd(0, 0, 1); upd(0, 0, 1); upd(0, 0, 0); set_hist(0);
    look(0, 1, "R4 hold 11 then 10");
    upd(0, 0, 0); set_hist(0); look(0, 0, "R3 01 predicts not taken");
    upd(0, 0, 0); upd(0, 0, 0); upd(0, 0, 1); set_hist(0);
    look(0, 0, "R4 hold 00 then 01");
    @(negedge clk); up_pc = pcf(0); up_hist = 0; up_taken = 1;
    @(negedge clk); @(negedge clk);
    look(0, 0, "R11 no train when invalid");
    upd(0, 0, 1); set_hist(0); look(0, 1, "R4 01->10");
  endtask

  task automatic t_hysteresis();
    idx_mode = 0; hyst_mode = 1;
    upd(0, 1, 0); set_hist(1); look(0, 0, "R5 10->00");
    upd(0, 1, 1); set_hist(1); look(0, 0, "R5 00->01");
    upd(0, 1, 1); upd(0, 1, 0); set_hist(1); look(0, 1, "R6 01->11->10");
    upd(0, 1, 0); set_hist(1); look(0, 0, "R5 second drop");
    hyst_mode = 0;
  endtask

  task automatic t_global();
    idx_mode = 0;
    upd(1, 2, 0); upd(1, 2, 0); set_hist(2);
    look(2, 0, "R7 other address");
    look(9, 0, "R7 far address");
    set_hist(3); look(1, 1, "R7 history selects");
  endtask

  task automatic t_perset();
    idx_mode = 1;
    upd(1, 3, 0); upd(1, 3, 0); set_hist(3);
    look(1, 0, "R8 own set");
    look(2, 1, "R8 other set");
    look(5, 0, "R8 set field only low bits");
    set_hist(4); look(1, 1, "R8 other history");
  endtask

  task automatic t_concat();
    idx_mode = 2;
    set_hist(4); look(3, 0, "R9 layout {hist,set}");
    set_hist(3); look(1, 1, "R9 differs from per-set");
  endtask

  task automatic t_hash();
    idx_mode = 3;
    upd(3, 5, 0); upd(3, 5, 0); set_hist(5);
    look(3, 0, "R10 own entry");
    look(6, 1, "R10 distinct xor");
    set_hist(6); look(0, 0, "R10 xor alias");
  endtask

  task automatic t_correlate();
    int miss = 0;
    logic p;
    logic [HIST_W-1:0] h;
    do_reset();
    idx_mode = 1; hyst_mode = 0;
    for (int it = 0; it < 16; it++) begin
      for (int b = 1; b <= 2; b++) begin
        logic o;
        o = (it % 2 == 1);
        @(negedge clk); lk_pc = pcf(b); #1;
        p = lk_taken; h = lk_hist;
        if (it >= 6 && p != o) miss++;
        upd(b, int'(h), o);
      end
    end
    chk(miss, 0, "R12 correlated pattern mispredicts");
    do_reset();
    #1 look(1, 1, "R1 reset restores counters");
  endtask

  initial begin
    t_reset();
    t_history();
    do_reset();
    t_saturate();
    t_hysteresis();
    t_global();
    t_perset();
    t_concat();
    t_hash();
    t_correlate();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule